// File: doc/BRIEF.md
# Serial FIFO Request Controller

This block turns the status flags of a FIFO-buffered serial port into service requests. It watches six flags: transmit FIFO empty, receive FIFO full, receive data ready, receive error, break and overrun. From them it derives four request sources: transmit, receive, error and line-break. Each source has its own registered, level-sensitive CPU interrupt line. Three enable bits gate the sources. A mode bit selects asynchronous or clocked-synchronous operation, and the data-ready timeout only counts in asynchronous mode.

The transmit and receive sources can each be steered to a DMA request instead of the CPU line. A DMA request is held until a one-cycle acknowledge. The acknowledge makes the block emit a one-cycle flag-clear pulse, then keep that request low for a short holdoff so the status logic has time to drop the flag. The error and break sources always go to the CPU. A registered source ID names the highest-priority CPU line that is asserted.

Top module: `sirq_ctrl`

## Requirements
- R1: One cycle after the inputs are sampled, `irq_tx` is 1 exactly when `en_tx`=1, `tx_empty_flag`=1 and `dma_tx_sel`=0.
- R2: One cycle after sampling, `irq_rx` is 1 exactly when `en_rx`=1, `dma_rx_sel`=0 and either `rx_full_flag`=1 or (`rx_ready_flag`=1 and `mode_sync`=0).
- R3: When `mode_sync`=1, `rx_ready_flag` has no effect: `irq_rx` and `dreq_rx` follow `rx_full_flag` alone. Also, when `en_rx`=0 and `en_err`=1, neither `irq_rx` nor `dreq_rx` rises.
- R4: One cycle after sampling, `irq_err` is 1 exactly when `en_err`=1 and `rx_err_flag`=1, whatever the DMA selects are.
- R5: One cycle after sampling, `irq_brk` is 1 exactly when (`en_rx`=1 or `en_err`=1) and (`brk_flag`=1 or `ovr_flag`=1), whatever the DMA selects are.
- R6: With `dma_tx_sel`=1 (or `dma_rx_sel`=1), the transmit (or receive) condition of R1 (or R2) drives `dreq_tx` (or `dreq_rx`) one cycle later, and the matching CPU line stays 0. Without an acknowledge, `dreq_*` follows the condition each cycle.
- R7: When `dack_*`=1 is sampled while `dreq_*`=1, the next cycle has `dreq_*`=0 and `clr_*`=1 for exactly one cycle. `dreq_*` then stays 0 for HOLD_CYC=2 further cycles before it follows the condition again. An acknowledge sampled while `dreq_*`=0 produces no `clr_*` pulse.
- R8: `src_id` is registered alongside the CPU lines and encodes the highest asserted line, with priority break > error > receive > transmit. The codes are 4 = break, 3 = error, 2 = receive, 1 = transmit and 0 = none.
- R9: While `rst` is 1 at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_empty_flag | input | 1 | Transmit FIFO empty status |
| rx_full_flag | input | 1 | Receive FIFO full status |
| rx_ready_flag | input | 1 | Receive data-ready timeout status |
| rx_err_flag | input | 1 | Receive framing/parity error status |
| brk_flag | input | 1 | Line break detected |
| ovr_flag | input | 1 | Receive overrun |
| en_tx | input | 1 | Transmit request enable |
| en_rx | input | 1 | Receive request enable |
| en_err | input | 1 | Error request enable |
| mode_sync | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| dma_tx_sel | input | 1 | Steer transmit source to DMA |
| dma_rx_sel | input | 1 | Steer receive source to DMA |
| dack_tx | input | 1 | Transmit DMA acknowledge pulse |
| dack_rx | input | 1 | Receive DMA acknowledge pulse |
| irq_tx | output | 1 | Transmit CPU interrupt |
| irq_rx | output | 1 | Receive CPU interrupt |
| irq_err | output | 1 | Error CPU interrupt |
| irq_brk | output | 1 | Break/overrun CPU interrupt |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |
| clr_tx | output | 1 | Transmit flag-clear pulse |
| clr_rx | output | 1 | Receive flag-clear pulse |
| src_id | output | 3 | Highest-priority active source code |

## Verification
An acknowledge can arrive in the same cycle as a change of DMA routing. The bench provokes this by asserting `dack_tx` together with dropping `dma_tx_sel` while `dreq_tx` is high. It then expects the clear pulse, a low `dreq_tx` and the CPU line `irq_tx` rising, all on the following edge. Break and error can also be active in the same cycle. The full sweep of every flag, enable, mode and routing combination checks that `src_id` then names break and that both lines are high.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TX   = 3'd1,
        SRC_RX   = 3'd2,
        SRC_ERR  = 3'd3,
        SRC_BRK  = 3'd4
    } src_e;

    typedef struct packed {
        logic brk;
        logic err;
        logic rx;
        logic tx;
    } req_t;

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic rx_ready;
        logic rx_err;
        logic brk;
        logic ovr;
    } flags_t;

    typedef struct packed {
        logic tx;
        logic rx;
        logic err;
    } enables_t;

    localparam int unsigned HOLD_CYC_DEF = 2;

    // Fixed order: break beats error beats receive beats transmit
    function automatic src_e top_source(req_t r);
        if (r.brk)     return SRC_BRK;
        else if (r.err) return SRC_ERR;
        else if (r.rx)  return SRC_RX;
        else if (r.tx)  return SRC_TX;
        else            return SRC_NONE;
    endfunction

endpackage

// File: rtl/sirq_src_gate.sv
module sirq_src_gate
    import sirq_pkg::*;
(
    input  flags_t   flags,
    input  enables_t en,
    input  logic     mode_sync,
    output req_t     cond
);
    logic rx_cause;

    // data-ready timeout only meaningful in asynchronous mode
    assign rx_cause = flags.rx_full | (flags.rx_ready & ~mode_sync);

    always_comb begin
        cond     = '0;
        cond.tx  = en.tx & flags.tx_empty;
        cond.rx  = en.rx & rx_cause;
        cond.err = en.err & flags.rx_err;
        cond.brk = (en.rx | en.err) & (flags.brk | flags.ovr);
    end

    always_comb begin
        if (!en.rx) begin
            assert (!cond.rx) else $error("receive cause while disabled");
        end
    end
endmodule

// File: rtl/sirq_dma_chan.sv
module sirq_dma_chan #(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic dack,
    output logic dreq,
    output logic clr
);
    localparam int unsigned CW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC);

    logic [CW-1:0] hold_cnt;
    logic          taken;

    assign taken = dack & dreq;

    always_ff @(posedge clk) begin
        if (rst) begin
            dreq     <= 1'b0;
            clr      <= 1'b0;
            hold_cnt <= '0;
        end else begin
            clr <= taken;
            if (taken) begin
                dreq     <= 1'b0;
                hold_cnt <= HOLD_LD;
            end else if (hold_cnt != '0) begin
                dreq     <= 1'b0;
                hold_cnt <= hold_cnt - 1'b1;
            end else begin
                dreq <= want;
            end
        end
    end

    // R7
    clr_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        clr |-> $past(dreq && dack));
    // R7
    drop_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (dreq && dack) |=> (!dreq && clr));
    // R7
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !clr);
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
    import sirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t cpu_next,
    output req_t cpu_q,
    output src_e id_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_q <= '0;
            id_q  <= SRC_NONE;
        end else begin
            cpu_q <= cpu_next;
            id_q  <= top_source(cpu_next);
        end
    end

    // R8
    id_brk_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_q.brk |-> (id_q == SRC_BRK));
    // R8
    id_none_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_q == '0) |-> (id_q == SRC_NONE));
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int unsigned HOLD_CYC = HOLD_CYC_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_empty_flag,
    input  logic       rx_full_flag,
    input  logic       rx_ready_flag,
    input  logic       rx_err_flag,
    input  logic       brk_flag,
    input  logic       ovr_flag,
    input  logic       en_tx,
    input  logic       en_rx,
    input  logic       en_err,
    input  logic       mode_sync,
    input  logic       dma_tx_sel,
    input  logic       dma_rx_sel,
    input  logic       dack_tx,
    input  logic       dack_rx,
    output logic       irq_tx,
    output logic       irq_rx,
    output logic       irq_err,
    output logic       irq_brk,
    output logic       dreq_tx,
    output logic       dreq_rx,
    output logic       clr_tx,
    output logic       clr_rx,
    output logic [2:0] src_id
);
    localparam int NCH = 2;

    flags_t   flags;
    enables_t en;
    req_t     cond;
    req_t     cpu_next;
    req_t     cpu_q;
    src_e     id_q;
    logic [NCH-1:0] ch_sel, ch_cond, ch_ack, ch_req, ch_clr;

    assign flags = '{tx_empty: tx_empty_flag, rx_full: rx_full_flag,
                     rx_ready: rx_ready_flag, rx_err: rx_err_flag,
                     brk: brk_flag, ovr: ovr_flag};
    assign en    = '{tx: en_tx, rx: en_rx, err: en_err};

    sirq_src_gate gate_i (
        .flags     (flags),
        .en        (en),
        .mode_sync (mode_sync),
        .cond      (cond)
    );

    // channel 0 = transmit, channel 1 = receive
    assign ch_sel  = {dma_rx_sel, dma_tx_sel};
    assign ch_cond = {cond.rx, cond.tx};
    assign ch_ack  = {dack_rx, dack_tx};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_dma
            sirq_dma_chan #(.HOLD_CYC(HOLD_CYC)) chan_i (
                .clk  (clk),
                .rst  (rst),
                .want (ch_cond[c] & ch_sel[c]),
                .dack (ch_ack[c]),
                .dreq (ch_req[c]),
                .clr  (ch_clr[c])
            );
        end
    endgenerate

    always_comb begin
        cpu_next     = cond;
        cpu_next.tx  = cond.tx & ~dma_tx_sel;
        cpu_next.rx  = cond.rx & ~dma_rx_sel;
    end

    sirq_prio prio_i (
        .clk      (clk),
        .rst      (rst),
        .cpu_next (cpu_next),
        .cpu_q    (cpu_q),
        .id_q     (id_q)
    );

    assign irq_tx  = cpu_q.tx;
    assign irq_rx  = cpu_q.rx;
    assign irq_err = cpu_q.err;
    assign irq_brk = cpu_q.brk;
    assign dreq_tx = ch_req[0];
    assign dreq_rx = ch_req[1];
    assign clr_tx  = ch_clr[0];
    assign clr_rx  = ch_clr[1];
    assign src_id  = id_q;

    // R6
    tx_route_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_tx && dreq_tx));
    // R6
    rx_route_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_rx && dreq_rx));
    // R3
    sync_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sync && !rx_full_flag) |=> (!irq_rx && !dreq_rx));
    // R3
    err_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_rx && en_err) |=> (!irq_rx && !dreq_rx));
    // R5
    brk_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_rx && !en_err) |=> !irq_brk);
    // R1
    tx_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_tx |=> (!irq_tx && !dreq_tx));
endmodule

// File: tb/sirq_ctrl_tb.sv
module sirq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_empty_flag = 0, rx_full_flag = 0, rx_ready_flag = 0;
    logic rx_err_flag = 0, brk_flag = 0, ovr_flag = 0;
    logic en_tx = 0, en_rx = 0, en_err = 0, mode_sync = 0;
    logic dma_tx_sel = 0, dma_rx_sel = 0, dack_tx = 0, dack_rx = 0;
    logic irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx, clr_tx, clr_rx;
    logic [2:0] src_id;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sirq_ctrl dut_i (
        .clk(clk), .rst(rst),
        .tx_empty_flag(tx_empty_flag), .rx_full_flag(rx_full_flag),
        .rx_ready_flag(rx_ready_flag), .rx_err_flag(rx_err_flag),
        .brk_flag(brk_flag), .ovr_flag(ovr_flag),
        .en_tx(en_tx), .en_rx(en_rx), .en_err(en_err), .mode_sync(mode_sync),
        .dma_tx_sel(dma_tx_sel), .dma_rx_sel(dma_rx_sel),
        .dack_tx(dack_tx), .dack_rx(dack_rx),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err), .irq_brk(irq_brk),
        .dreq_tx(dreq_tx), .dreq_rx(dreq_rx), .clr_tx(clr_tx), .clr_rx(clr_rx),
        .src_id(src_id)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic e_tx, e_rx, e_err, e_brk, c_tx, c_rx;
        logic [2:0] e_id;
        step(); step();
        // R9 reset state
        check("R9 irq", {irq_tx, irq_rx, irq_err, irq_brk}, 4'd0);
        check("R9 dma", {dreq_tx, dreq_rx, clr_tx, clr_rx}, 4'd0);
        check("R9 id", {1'b0, src_id}, 4'd0);
        rst = 1'b0;

        // exhaustive sweep over 12 input bits, no acknowledges
        for (int v = 0; v < 4096; v++) begin
            {tx_empty_flag, rx_full_flag, rx_ready_flag, rx_err_flag, brk_flag, ovr_flag,
             en_tx, en_rx, en_err, mode_sync, dma_tx_sel, dma_rx_sel} = 12'(v);
            c_tx  = en_tx && tx_empty_flag;
            c_rx  = en_rx && (rx_full_flag || (rx_ready_flag && !mode_sync));
            e_tx  = c_tx && !dma_tx_sel;
            e_rx  = c_rx && !dma_rx_sel;
            e_err = en_err && rx_err_flag;
            e_brk = (en_rx || en_err) && (brk_flag || ovr_flag);
            e_id  = e_brk ? 3'd4 : e_err ? 3'd3 : e_rx ? 3'd2 : e_tx ? 3'd1 : 3'd0;
            step();
            check("R1 irq_tx", {3'b0, irq_tx}, {3'b0, e_tx});
            check("R2 R3 irq_rx", {3'b0, irq_rx}, {3'b0, e_rx});
            check("R4 irq_err", {3'b0, irq_err}, {3'b0, e_err});
            check("R5 irq_brk", {3'b0, irq_brk}, {3'b0, e_brk});
            check("R6 dreq_tx", {3'b0, dreq_tx}, {3'b0, c_tx && dma_tx_sel});
            check("R6 R3 dreq_rx", {3'b0, dreq_rx}, {3'b0, c_rx && dma_rx_sel});
            check("R8 src_id", {1'b0, src_id}, {1'b0, e_id});
        end

        // R7 acknowledge handshake with holdoff
        {tx_empty_flag, rx_full_flag, rx_ready_flag, rx_err_flag, brk_flag, ovr_flag} = '0;
        {en_rx, en_err, mode_sync, dma_rx_sel} = '0;
        tx_empty_flag = 1; en_tx = 1; dma_tx_sel = 1;
        step(); step();
        check("R7 dreq up", {3'b0, dreq_tx}, 4'd1);
        dack_tx = 1;
        step();
        dack_tx = 0;
        check("R7 dreq drop", {3'b0, dreq_tx}, 4'd0);
        check("R7 clr pulse", {3'b0, clr_tx}, 4'd1);
        dack_rx = 1;  // dreq_rx is low: must be ignored
        step();
        dack_rx = 0;
        check("R7 clr once", {3'b0, clr_tx}, 4'd0);
        check("R7 hold1", {3'b0, dreq_tx}, 4'd0);
        check("R7 rx ack ignored", {3'b0, clr_rx}, 4'd0);
        step();
        check("R7 hold2", {3'b0, dreq_tx}, 4'd0);
        step();
        check("R7 resume", {3'b0, dreq_tx}, 4'd1);

        // R7 R6 acknowledge coincident with routing back to CPU
        dack_tx = 1; dma_tx_sel = 0;
        step();
        dack_tx = 0;
        check("R7 coincident clr", {3'b0, clr_tx}, 4'd1);
        check("R7 coincident dreq", {3'b0, dreq_tx}, 4'd0);
        check("R6 coincident irq_tx", {3'b0, irq_tx}, 4'd1);
        check("R8 coincident id", {1'b0, src_id}, 4'd1);

        // R9 reset mid-activity
        rst = 1;
        step();
        check("R9 reset again", {irq_tx, irq_rx, irq_err, irq_brk}, 4'd0);
        check("R9 reset id", {1'b0, src_id}, 4'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule